// File: doc/BRIEF.md
# Shadowed Real-Time-Clock Register Bank

This block lets a retro CPU see an external real-time-clock chip as a plain bank of byte-wide registers. A local shadow copy of the chip's 32 time and control registers answers every CPU read in the same cycle. The CPU never waits for the slow serial bus. The chip registers hold date and time in BCD; the block moves the bytes and does not interpret them.

Once per second the block runs a fixed schedule of four equal phases: ready, grace, write-back and refresh. The CPU may read and write the shadow during the ready and grace phases. A status register reports a ready flag during the first phase only, so software that sees the flag set still has at least one full phase to finish its accesses.

If the CPU wrote any register since the last write-back, the whole bank is written to the chip in one burst transaction. The refresh phase then reads the whole bank back in one burst. Every field therefore comes from a single consistent snapshot. Both bursts go out on a byte-level transaction port, which a serial-bus master serves.

Top module: `rtc_shadow_bank`

## Requirements
- R1: A CPU read (cs_n=0, rd_n=0) of an address in 0x00..0x1F returns that shadow register on cpu_rdata in the same cycle, combinationally. cpu_rdata is 0x00 whenever no read is being made.
- R2: A CPU read of an address in 0x21..0x3F returns 0x00.
- R3: The status register sits at address 0x20. Bit 0 is the ready flag and is 1 only during the ready phase. Bits 7..1 read 0.
- R4: Each second is four phases of TICKS_PER_PHASE clock cycles in the fixed order ready, grace, write-back, refresh. After reset the block starts at the first cycle of the ready phase.
- R5: A CPU write (cs_n=0, wr_n=0) to an address in 0x00..0x1F during the ready or grace phase is stored in the shadow on that clock edge. It is visible to a read in the next cycle.
- R6: CPU writes made during the write-back or refresh phase change no shadow register and do not cause a write-back.
- R7: When the write-back phase begins after at least one accepted CPU write, one write burst starts. It carries register address 0 and count 32, and sends shadow bytes 0..31 in address order. The pending write-back is cleared when that burst completes. Without an accepted write, no write burst is issued.
- R8: When the refresh phase begins, one read burst starts with register address 0 and count 32. The received bytes overwrite shadow registers 0..31 in arrival order.
- R9: txn_start is a one-cycle pulse, issued only while txn_busy is low, with txn_count equal to 32.
- R10: After reset all shadow registers read 0x00, no write-back is pending, and the ready flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 6 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| cpu_cs_n | input | 1 | Chip select, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| txn_start | output | 1 | One-cycle request for a burst transaction |
| txn_rnw | output | 1 | Burst direction: 1 read from chip, 0 write to chip |
| txn_addr | output | 6 | First chip register of the burst |
| txn_count | output | 6 | Number of bytes in the burst |
| txn_busy | input | 1 | Transaction port is executing a burst |
| txn_done | input | 1 | One-cycle pulse when the burst finishes |
| wr_data | output | 8 | Byte sent to the chip |
| wr_valid | output | 1 | wr_data is valid |
| wr_ready | input | 1 | Transaction port accepts wr_data |
| rd_data | input | 8 | Byte received from the chip |
| rd_valid | input | 1 | rd_data is valid |
| rd_ready | output | 1 | Block accepts rd_data |

## Verification
Read data is combinational, so the bench samples it one nanosecond after it drives the strobes, within the same cycle. A write is driven on a falling edge and taken on the next rising edge, so it is read back one cycle later. Phase membership of a write depends on the cycle count at the falling edge where it is driven. The ready flag is compared at every cycle of a whole second against the phase computed from the cycles elapsed since reset. The bench tests the grace/write-back boundary with writes driven on the last grace cycle and on the first write-back cycle. Bursts start two to three cycles after their phase begins and end well inside it. The bench therefore checks the chip model and the shadow two cycles into the following second.

// File: rtl/rtc_shadow_pkg.sv
// Shared types for the shadowed RTC register bank.
// Assumes: nothing beyond standard SystemVerilog.
package rtc_shadow_pkg;

    // Four phases of each second, in schedule order
    typedef enum logic [1:0] {
        PH_READY   = 2'd0,
        PH_GRACE   = 2'd1,
        PH_WBACK   = 2'd2,
        PH_REFRESH = 2'd3
    } phase_t;

    // Burst sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_XFER = 2'd2
    } seq_t;

endpackage

// File: rtl/rtc_phase_timer.sv
// Phase timer: divides the clock into phases of TICKS cycles and steps
// through the four phases in order. It gives one-cycle pulses in the
// first cycle of the write-back and refresh phases.
// Assumes: TICKS >= 2.
module rtc_phase_timer
    import rtc_shadow_pkg::*;
#(
    parameter int TICKS = 6250000
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   enter_wb,
    output logic   enter_rf
);

    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == TW'(TICKS - 1));

    // Count ticks, advance the phase at each wrap, flag phase entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            phase    <= PH_READY;
            enter_wb <= 1'b0;
            enter_rf <= 1'b0;
        end else begin
            enter_wb <= 1'b0;
            enter_rf <= 1'b0;
            if (wrap) begin
                tick     <= '0;
                phase    <= phase_t'(phase + 2'd1);
                enter_wb <= (phase == PH_GRACE);
                enter_rf <= (phase == PH_WBACK);
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_shadow_regs.sv
// Shadow register file: NREGS bytes with one CPU write port, one
// sequencer write port and two combinational read ports.
// Assumes: the two write ports are never used in the same cycle (the
// phase schedule keeps them apart); the sequencer port wins if they are.
module rtc_shadow_regs #(
    parameter int NREGS = 32,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_we,
    input  logic [$clog2(NREGS)-1:0] cpu_idx,
    input  logic [DW-1:0]            cpu_wdata,
    input  logic                     seq_we,
    input  logic [$clog2(NREGS)-1:0] seq_idx,
    input  logic [DW-1:0]            seq_wdata,
    output logic [DW-1:0]            cpu_rbyte,
    output logic [DW-1:0]            seq_rbyte
);

    logic [DW-1:0] mem [NREGS];

    // Clear on reset, otherwise take the active write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= '0;
            end
        end else if (seq_we) begin
            mem[seq_idx] <= seq_wdata;
        end else if (cpu_we) begin
            mem[cpu_idx] <= cpu_wdata;
        end
    end

    assign cpu_rbyte = mem[cpu_idx];
    assign seq_rbyte = mem[seq_idx];

endmodule

// File: rtl/rtc_burst_seq.sv
// Burst sequencer: on phase-entry pulses it queues a whole-bank write
// (only if dirty) or a whole-bank read. It issues each burst on the
// transaction port and streams the bytes to or from the shadow.
// Assumes: the port raises txn_busy the cycle after txn_start and pulses
// txn_done after the last byte has moved.
module rtc_burst_seq
    import rtc_shadow_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int DW    = 8,
    parameter int AW    = 6,
    parameter int CW    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enter_wb,
    input  logic                     enter_rf,
    input  logic                     dirty,
    output logic                     txn_start,
    output logic                     txn_rnw,
    output logic [AW-1:0]            txn_addr,
    output logic [CW-1:0]            txn_count,
    input  logic                     txn_busy,
    input  logic                     txn_done,
    output logic [DW-1:0]            wr_data,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    input  logic [DW-1:0]            rd_data,
    input  logic                     rd_valid,
    output logic                     rd_ready,
    output logic [$clog2(NREGS)-1:0] sh_idx,
    input  logic [DW-1:0]            sh_rbyte,
    output logic                     sh_we,
    output logic [DW-1:0]            sh_wdata,
    output logic                     wb_done
);

    localparam int IW = $clog2(NREGS);

    seq_t        st;
    logic        is_rd;
    logic [IW:0] idx;
    logic        pend_wr;
    logic        pend_rd;
    logic        all_moved;

    assign all_moved = (idx == (IW+1)'(NREGS));
    assign txn_start = (st == SQ_REQ);
    assign txn_rnw   = is_rd;
    assign txn_addr  = '0;
    assign txn_count = CW'(NREGS);
    assign sh_idx    = idx[IW-1:0];
    assign wr_data   = sh_rbyte;
    assign wr_valid  = (st == SQ_XFER) && !is_rd && !all_moved;
    assign rd_ready  = (st == SQ_XFER) && is_rd && !all_moved;
    assign sh_we     = rd_ready && rd_valid;
    assign sh_wdata  = rd_data;
    assign wb_done   = (st == SQ_XFER) && !is_rd && all_moved && txn_done;

    // Queue bursts on phase entry, then request, stream and finish them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            is_rd   <= 1'b0;
            idx     <= '0;
            pend_wr <= 1'b0;
            pend_rd <= 1'b0;
        end else begin
            if (enter_wb && dirty) pend_wr <= 1'b1;
            if (enter_rf)          pend_rd <= 1'b1;
            case (st)
                SQ_IDLE: begin
                    if (pend_wr && !txn_busy) begin
                        st      <= SQ_REQ;
                        is_rd   <= 1'b0;
                        pend_wr <= 1'b0;
                    end else if (pend_rd && !txn_busy) begin
                        st      <= SQ_REQ;
                        is_rd   <= 1'b1;
                        pend_rd <= 1'b0;
                    end
                end
                SQ_REQ: begin
                    st  <= SQ_XFER;
                    idx <= '0;
                end
                SQ_XFER: begin
                    if ((wr_valid && wr_ready) || sh_we) idx <= idx + 1'b1;
                    if (all_moved && txn_done) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtc_shadow_bank.sv
// Top level: CPU-facing RTC register bank backed by a shadow copy. The
// shadow is synchronised once per second through the burst sequencer.
// Assumes: the CPU strobes are synchronous to clk; the register bank
// starts at chip register 0.
module rtc_shadow_bank
    import rtc_shadow_pkg::*;
#(
    parameter int CLK_HZ          = 25000000,
    parameter int TICKS_PER_PHASE = CLK_HZ / 4,
    parameter int NREGS           = 32,
    parameter int AW              = 6,
    parameter int DW              = 8,
    parameter int STATUS_ADDR     = 32,
    parameter int CW              = $clog2(NREGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_cs_n,
    input  logic          cpu_wr_n,
    input  logic          cpu_rd_n,
    output logic          txn_start,
    output logic          txn_rnw,
    output logic [AW-1:0] txn_addr,
    output logic [CW-1:0] txn_count,
    input  logic          txn_busy,
    input  logic          txn_done,
    output logic [DW-1:0] wr_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    output logic          rd_ready
);

    localparam int IW = $clog2(NREGS);

    phase_t        phase;
    logic          enter_wb;
    logic          enter_rf;
    logic          dirty;
    logic          wb_done;
    logic          cpu_rd;
    logic          cpu_wr;
    logic          in_bank;
    logic          cpu_accept;
    logic          rdy;
    logic [IW-1:0] seq_idx;
    logic          seq_we;
    logic [DW-1:0] seq_wdata;
    logic [DW-1:0] cpu_rbyte;
    logic [DW-1:0] seq_rbyte;

    assign cpu_rd     = !cpu_cs_n && !cpu_rd_n;
    assign cpu_wr     = !cpu_cs_n && !cpu_wr_n;
    assign in_bank    = (cpu_addr < AW'(NREGS));
    assign cpu_accept = cpu_wr && in_bank &&
                        ((phase == PH_READY) || (phase == PH_GRACE));
    assign rdy        = (phase == PH_READY);

    rtc_phase_timer #(.TICKS(TICKS_PER_PHASE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .enter_wb (enter_wb),
        .enter_rf (enter_rf)
    );

    rtc_shadow_regs #(.NREGS(NREGS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_accept),
        .cpu_idx   (cpu_addr[IW-1:0]),
        .cpu_wdata (cpu_wdata),
        .seq_we    (seq_we),
        .seq_idx   (seq_idx),
        .seq_wdata (seq_wdata),
        .cpu_rbyte (cpu_rbyte),
        .seq_rbyte (seq_rbyte)
    );

    rtc_burst_seq #(.NREGS(NREGS), .DW(DW), .AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_wb  (enter_wb),
        .enter_rf  (enter_rf),
        .dirty     (dirty),
        .txn_start (txn_start),
        .txn_rnw   (txn_rnw),
        .txn_addr  (txn_addr),
        .txn_count (txn_count),
        .txn_busy  (txn_busy),
        .txn_done  (txn_done),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .sh_idx    (seq_idx),
        .sh_rbyte  (seq_rbyte),
        .sh_we     (seq_we),
        .sh_wdata  (seq_wdata),
        .wb_done   (wb_done)
    );

    // Track whether the shadow holds writes not yet sent to the chip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (wb_done) begin
            dirty <= 1'b0;
        end else if (cpu_accept) begin
            dirty <= 1'b1;
        end
    end

    // Select the read byte: shadow, status or zero
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            if (in_bank) begin
                cpu_rdata = cpu_rbyte;
            end else if (cpu_addr == AW'(STATUS_ADDR)) begin
                cpu_rdata = {{(DW-1){1'b0}}, rdy};
            end
        end
    end

endmodule

// File: rtl/rtc_shadow_chk.sv
// Checker for the shadowed RTC bank: phase order, burst timing and the
// transaction handshake. Attached to every instance of the top by bind.
// Assumes: synchronous active-low reset shared with the design.
module rtc_shadow_chk #(
    parameter int NREGS = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    phase,
    input logic          dirty,
    input logic          txn_start,
    input logic          txn_rnw,
    input logic          txn_busy,
    input logic          txn_done,
    input logic [CW-1:0] txn_count
);

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> !txn_busy);

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !txn_start);

    // R9
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (txn_count == CW'(NREGS)));

    // R7
    wb_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !txn_rnw) |-> ((phase == 2'd2) && dirty));

    // R7
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !txn_rnw) |=> !dirty);

    // R8
    rf_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && txn_rnw) |-> (phase == 2'd3));

    // R4
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (phase == 2'($past(phase) + 2'd1)));

endmodule

bind rtc_shadow_bank rtc_shadow_chk #(.NREGS(NREGS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .dirty     (dirty),
    .txn_start (txn_start),
    .txn_rnw   (txn_rnw),
    .txn_busy  (txn_busy),
    .txn_done  (txn_done),
    .txn_count (txn_count)
);

// File: tb/sim_rtc_shadow_bank.sv
`timescale 1ns/1ps
// Bench for the shadowed RTC bank. A small phase length is used, and a
// behavioural transaction port with a 32-byte chip memory is built in.
module sim_rtc_shadow_bank;

    localparam int T   = 64;
    localparam int SEC = 4 * T;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_cs_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic       cpu_rd_n = 1'b1;
    logic       txn_start, txn_rnw, txn_busy, txn_done;
    logic [5:0] txn_addr, txn_count;
    logic [7:0] wr_data, rd_data;
    logic       wr_valid, wr_ready, rd_valid, rd_ready;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // chip-side model state
    logic [7:0] mem [32];
    logic       m_busy, m_rnw;
    logic [5:0] m_idx;
    int         wr_cnt, rd_cnt, bad_start, bad_count, bad_phase;
    logic       poke_en = 1'b0;
    logic [4:0] poke_addr = '0;
    logic [7:0] poke_val = '0;

    always #4 clk = ~clk;

    rtc_shadow_bank #(.TICKS_PER_PHASE(T)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_cs_n(cpu_cs_n), .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n),
        .txn_start(txn_start), .txn_rnw(txn_rnw), .txn_addr(txn_addr),
        .txn_count(txn_count), .txn_busy(txn_busy), .txn_done(txn_done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    assign txn_busy = m_busy;
    assign wr_ready = m_busy && !m_rnw && (m_idx != 6'd32);
    assign rd_valid = m_busy && m_rnw && (m_idx != 6'd32);
    assign rd_data  = mem[m_idx[4:0]];

    // Transaction port and chip memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 3 + 1);
            m_busy <= 1'b0; m_rnw <= 1'b0; m_idx <= '0; txn_done <= 1'b0;
            wr_cnt <= 0; rd_cnt <= 0; bad_start <= 0; bad_count <= 0; bad_phase <= 0;
        end else begin
            txn_done <= 1'b0;
            if (poke_en) mem[poke_addr] <= poke_val;
            if (txn_start) begin
                if (m_busy) bad_start <= bad_start + 1;
                if (txn_count != 6'd32 || txn_addr != 6'd0) bad_count <= bad_count + 1;
                m_busy <= 1'b1; m_rnw <= txn_rnw; m_idx <= '0;
                if (txn_rnw) begin
                    rd_cnt <= rd_cnt + 1;
                    if ((cyc / T) % 4 != 3) bad_phase <= bad_phase + 1;
                end else begin
                    wr_cnt <= wr_cnt + 1;
                    if ((cyc / T) % 4 != 2) bad_phase <= bad_phase + 1;
                end
            end else if (m_busy) begin
                if (m_idx == 6'd32) begin
                    m_busy <= 1'b0; txn_done <= 1'b1;
                end else if (!m_rnw && wr_valid) begin
                    mem[m_idx[4:0]] <= wr_data; m_idx <= m_idx + 1'b1;
                end else if (m_rnw && rd_ready) begin
                    m_idx <= m_idx + 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic goto_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [5:0] a, output int d);
        cpu_addr = a; cpu_cs_n = 1'b0; cpu_rd_n = 1'b0;
        #1 d = int'(cpu_rdata);
        cpu_cs_n = 1'b1; cpu_rd_n = 1'b1;
    endtask

    task automatic cpu_write(input logic [5:0] a, input logic [7:0] v);
        cpu_addr = a; cpu_wdata = v; cpu_cs_n = 1'b0; cpu_wr_n = 1'b0;
        @(posedge clk); @(negedge clk);
        cpu_cs_n = 1'b1; cpu_wr_n = 1'b1;
    endtask

    task automatic poke(input logic [4:0] a, input logic [7:0] v);
        poke_addr = a; poke_val = v; poke_en = 1'b1;
        @(posedge clk); @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R3 status after reset
        cpu_read(6'h20, d); chk("R10 R3 status after reset", d, 1);
        bad = 0;
        for (int i = 0; i < 32; i++) begin cpu_read(6'(i), d); if (d != 0) bad++; end
        chk("R10 shadow cleared", bad, 0);
        // R1 no read strobe gives zero
        #1 chk("R1 idle rdata", int'(cpu_rdata), 0);
        // R2 unmapped addresses
        bad = 0;
        for (int i = 33; i < 64; i++) begin cpu_read(6'(i), d); if (d != 0) bad++; end
        chk("R2 unmapped reads", bad, 0);

        // R3 R4 ready flag over a whole second
        bad = 0;
        for (int c = 0; c < SEC; c++) begin
            goto_cyc(c); cpu_read(6'h20, d);
            if (d != (((c / T) % 4 == 0) ? 1 : 0)) bad++;
        end
        chk("R3 R4 ready flag sweep", bad, 0);

        // R8 first refresh loads the chip image; R7 no write-back without writes
        goto_cyc(SEC + 2);
        chk("R7 no write burst when clean", wr_cnt, 0);
        chk("R8 one read burst", rd_cnt, 1);
        bad = 0;
        for (int i = 0; i < 32; i++) begin cpu_read(6'(i), d); if (d != i * 3 + 1) bad++; end
        chk("R8 shadow equals chip", bad, 0);

        // R5 writes in ready and grace phases; R1 immediate read-back
        goto_cyc(SEC + 10); cpu_write(6'd5, 8'h42);
        cpu_read(6'd5, d); chk("R5 R1 ready-phase write", d, 8'h42);
        goto_cyc(SEC + T + 5); cpu_write(6'd9, 8'h99);
        cpu_read(6'd9, d); chk("R5 grace-phase write", d, 8'h99);
        // R6 writes in write-back and refresh phases ignored
        goto_cyc(SEC + 2 * T + 5); cpu_write(6'd12, 8'h77);
        cpu_read(6'd12, d); chk("R6 write-back-phase write ignored", d, 37);
        goto_cyc(SEC + 3 * T + 5); cpu_write(6'd13, 8'h55);
        cpu_read(6'd13, d); chk("R6 refresh-phase write ignored", d, 40);

        // R7 write-back reached the chip
        goto_cyc(2 * SEC + 2);
        chk("R7 one write burst", wr_cnt, 1);
        chk("R7 chip reg5", int'(mem[5]), 8'h42);
        chk("R7 chip reg9", int'(mem[9]), 8'h99);
        chk("R6 chip reg12 unchanged", int'(mem[12]), 37);
        chk("R6 chip reg13 unchanged", int'(mem[13]), 40);
        chk("R8 two read bursts", rd_cnt, 2);

        // R8 chip-side changes appear after the next refresh
        goto_cyc(2 * SEC + 10); poke(5'd0, 8'h59); poke(5'd31, 8'hA5);
        goto_cyc(3 * SEC + 2);
        chk("R7 dirty cleared, no second write burst", wr_cnt, 1);
        bad = 0;
        for (int i = 0; i < 32; i++) begin cpu_read(6'(i), d); if (d != int'(mem[i])) bad++; end
        chk("R8 shadow matches changed chip", bad, 0);
        cpu_read(6'd0, d);  chk("R8 reg0 refreshed", d, 8'h59);
        cpu_read(6'd31, d); chk("R8 reg31 refreshed", d, 8'hA5);

        // R5 R6 grace/write-back boundary
        goto_cyc(3 * SEC + 2 * T - 1); cpu_write(6'd20, 8'h20);
        cpu_write(6'd21, 8'hEE);
        cpu_read(6'd21, d); chk("R6 first write-back cycle ignored", d, 64);
        goto_cyc(4 * SEC + 2);
        chk("R5 last grace cycle written back", int'(mem[20]), 8'h20);
        chk("R6 chip reg21 unchanged", int'(mem[21]), 64);
        cpu_read(6'd20, d); chk("R8 reg20 after refresh", d, 8'h20);
        chk("R7 second write burst", wr_cnt, 2);

        // R9 handshake rules; R4 bursts start in their phases
        chk("R9 start while busy", bad_start, 0);
        chk("R9 burst address and count", bad_count, 0);
        chk("R4 burst phase placement", bad_phase, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule